// File: doc/BRIEF.md
# ADC Register Configuration Serial Writer

This block loads the setup registers of a multi-channel external analog-to-digital converter. The converter is written over a three-wire serial link made of an active-low chip select, a serial clock and a serial data line. The block stays idle until two controls are both high: an operation run control and a conversion enable setting. It then works through a table of register address and data pairs fixed at build time. Each pair goes out as one 16-bit write frame, with chip select held low for the whole frame.

Each frame begins with two command bits, both driven low: the active-low write enable and the read/write select, where low means write. A 6-bit register address follows, then an 8-bit data byte, all sent most significant bit first. The serial clock is divided down from the system clock. The data line moves only when the serial clock falls, so the converter can sample it on the rising edge. After the last frame a configuration-done flag goes high. Dropping either control at any time stops the transfer and clears the flag. The next time both controls are high, the walk starts again from the first entry.

Top module: `adc_cfg_writer`

## Requirements
- R1: While `run_start` and `conv_enable` are not both 1, the outputs hold idle: `adc_cs_n`=1, `adc_sclk`=1, `cfg_sdata`=0, `cfg_done`=0. The first frame starts on the clock edge that first sees both at 1.
- R2: A frame carries 16 bits, most significant first. Bit 15 is the active-low write enable and is always 0. Bit 14 is read/write and is always 0 (write). Bits 13..8 are the register address, MSB first. Bits 7..0 are the data byte, MSB first.
- R3: `adc_cs_n` stays low for exactly 32*SCLK_HALF system clocks per frame. Between two frames it is high for exactly CS_GAP system clocks, and CS_GAP is at least 2.
- R4: `adc_sclk` is high whenever `adc_cs_n` is high. Inside a frame, each bit is SCLK_HALF clocks of `adc_sclk` low followed by SCLK_HALF clocks high. `cfg_sdata` changes only in the cycle where `adc_sclk` falls, and is 0 while `adc_cs_n` is high.
- R5: Entries go out in index order 0 to N_ENTRIES-1. Entry i occupies CFG_TABLE[i*14 +: 14] as {address[5:0], data[7:0]}.
- R6: `cfg_done` goes to 1 in the same cycle that `adc_cs_n` rises after the last frame. It stays at 1 while both controls remain 1.
- R7: If either control drops, the cycle after that edge shows idle outputs with `cfg_done`=0. When both controls are 1 again, sending restarts from entry 0.
- R8: A synchronous active-high `rst` puts the outputs in the idle state of R1. When `rst` is released, the sequence starts again from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Operation run control (1 = run) |
| conv_enable | input | 1 | Conversion enable setting (1 = enabled) |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter, idles high |
| cfg_sdata | output | 1 | Serial write data to the converter |
| cfg_done | output | 1 | All table entries have been written |

## Verification
A wrong bit counter or half-period counter shows up on `adc_cs_n` and `adc_sclk` as a frame of the wrong length. The mismatch appears at the first frame boundary, within 32*SCLK_HALF clocks of the start. A slip in the shift register or the table index shows up on `cfg_sdata` at the first rising serial-clock edge where the bit differs. The bench also rebuilds whole received words, so a wrong address or data byte is caught by word. A fault in the done or abort logic shows up in `cfg_done` or chip select one clock after the last frame ends, or one clock after a control drops.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;
  localparam int ENTRY_W = ADDR_W + DATA_W;
  localparam int FRAME_W = ENTRY_W + 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_GAP,
    ST_DONE
  } seq_state_t;

  // Write frame: write-enable (active low) = 0, read/write = 0 (write), then entry
  function automatic logic [FRAME_W-1:0] build_frame(input logic [ENTRY_W-1:0] entry);
    return {1'b0, 1'b0, entry};
  endfunction
endpackage

// File: rtl/adc_cfg_table.sv
module adc_cfg_table import adc_cfg_pkg::*; #(
  parameter int N_ENTRIES = 4,
  parameter int IDX_W     = 2,
  parameter logic [N_ENTRIES*ENTRY_W-1:0] CFG_TABLE = '0
) (
  input  logic [IDX_W-1:0]   idx,
  output logic [FRAME_W-1:0] frame
);
  logic [ENTRY_W-1:0] entries [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    assign entries[g] = CFG_TABLE[g*ENTRY_W +: ENTRY_W];
  end

  always_comb begin
    if (int'(idx) < N_ENTRIES) frame = build_frame(entries[idx]);
    else                        frame = '0;
  end
endmodule

// File: rtl/adc_cfg_baud.sv
module adc_cfg_baud #(
  parameter int SCLK_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic half_end
);
  localparam int CNT_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SCLK_HALF - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active)        cnt <= '0;
    else if (cnt == CNT_LAST)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign half_end = active && (cnt == CNT_LAST);
endmodule

// File: rtl/adc_cfg_seq.sv
module adc_cfg_seq import adc_cfg_pkg::*; #(
  parameter int N_ENTRIES = 4,
  parameter int CS_GAP    = 2,
  parameter int IDX_W     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               gate,
  input  logic               half_end,
  input  logic [FRAME_W-1:0] frame,
  output logic [IDX_W-1:0]   idx,
  output logic               xfer_active,
  output logic               cs_n,
  output logic               sclk,
  output logic               sdata,
  output logic               done
);
  localparam int GAP_W = $clog2(CS_GAP);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_ENTRIES - 1);
  localparam logic [3:0]       BIT_LAST = 4'(FRAME_W - 1);

  seq_state_t         state;
  logic [FRAME_W-2:0] shreg;
  logic [3:0]         bitc;
  logic               ph;
  logic [GAP_W-1:0]   gcnt;

  always_ff @(posedge clk) begin
    if (rst || !gate) begin
      state <= ST_IDLE;
      idx   <= '0;
      shreg <= '0;
      bitc  <= '0;
      ph    <= 1'b0;
      gcnt  <= '0;
      cs_n  <= 1'b1;
      sclk  <= 1'b1;
      sdata <= 1'b0;
      done  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_XFER;
          cs_n  <= 1'b0;
          sclk  <= 1'b0;
          sdata <= frame[FRAME_W-1];
          shreg <= frame[FRAME_W-2:0];
          bitc  <= '0;
          ph    <= 1'b0;
        end
        ST_XFER: begin
          if (half_end) begin
            if (!ph) begin
              sclk <= 1'b1;
              ph   <= 1'b1;
            end else if (bitc == BIT_LAST) begin
              cs_n  <= 1'b1;
              sclk  <= 1'b1;
              sdata <= 1'b0;
              ph    <= 1'b0;
              bitc  <= '0;
              if (idx == IDX_LAST) begin
                state <= ST_DONE;
                done  <= 1'b1;
              end else begin
                idx   <= idx + 1'b1;
                gcnt  <= '0;
                state <= ST_GAP;
              end
            end else begin
              bitc  <= bitc + 1'b1;
              ph    <= 1'b0;
              sclk  <= 1'b0;
              sdata <= shreg[FRAME_W-2];
              shreg <= {shreg[FRAME_W-3:0], 1'b0};
            end
          end
        end
        ST_GAP: begin
          if (gcnt == GAP_LAST) begin
            state <= ST_XFER;
            cs_n  <= 1'b0;
            sclk  <= 1'b0;
            sdata <= frame[FRAME_W-1];
            shreg <= frame[FRAME_W-2:0];
            bitc  <= '0;
            ph    <= 1'b0;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        ST_DONE: ;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign xfer_active = (state == ST_XFER);
endmodule

// File: rtl/adc_cfg_writer.sv
module adc_cfg_writer import adc_cfg_pkg::*; #(
  parameter int N_ENTRIES = 4,
  parameter int SCLK_HALF = 4,
  parameter int CS_GAP    = 2,
  parameter logic [N_ENTRIES*ENTRY_W-1:0] CFG_TABLE =
    {6'h03, 8'h0F, 6'h02, 8'hA5, 6'h01, 8'h3C, 6'h00, 8'h81}
) (
  input  logic clk,
  input  logic rst,
  input  logic run_start,
  input  logic conv_enable,
  output logic adc_cs_n,
  output logic adc_sclk,
  output logic cfg_sdata,
  output logic cfg_done
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic               gate;
  logic               half_end;
  logic               xfer_active;
  logic [IDX_W-1:0]   idx;
  logic [FRAME_W-1:0] frame;

  assign gate = run_start & conv_enable;

  adc_cfg_table #(
    .N_ENTRIES (N_ENTRIES),
    .IDX_W     (IDX_W),
    .CFG_TABLE (CFG_TABLE)
  ) table_i (
    .idx   (idx),
    .frame (frame)
  );

  adc_cfg_baud #(
    .SCLK_HALF (SCLK_HALF)
  ) baud_i (
    .clk      (clk),
    .rst      (rst),
    .active   (xfer_active),
    .half_end (half_end)
  );

  adc_cfg_seq #(
    .N_ENTRIES (N_ENTRIES),
    .CS_GAP    (CS_GAP),
    .IDX_W     (IDX_W)
  ) seq_i (
    .clk         (clk),
    .rst         (rst),
    .gate        (gate),
    .half_end    (half_end),
    .frame       (frame),
    .idx         (idx),
    .xfer_active (xfer_active),
    .cs_n        (adc_cs_n),
    .sclk        (adc_sclk),
    .sdata       (cfg_sdata),
    .done        (cfg_done)
  );
endmodule

// File: rtl/adc_cfg_writer_chk.sv
module adc_cfg_writer_chk (
  input logic clk,
  input logic rst,
  input logic run_start,
  input logic conv_enable,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic cfg_sdata,
  input logic cfg_done
);
  logic gate;
  assign gate = run_start & conv_enable;

  // R1 / R7: gating or abort forces idle outputs on the next cycle
  a_r1_idle_when_gated: assert property (@(posedge clk) disable iff (rst)
    !gate |=> (adc_cs_n && adc_sclk && !cfg_sdata && !cfg_done));

  // R4: serial clock high outside a frame
  a_r4_sclk_idle_high: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> adc_sclk);

  // R4: data line low outside a frame
  a_r4_data_low_idle: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> !cfg_sdata);

  // R4: inside a frame data moves only with a falling serial clock
  a_r4_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!adc_cs_n && $past(!adc_cs_n) && !$fell(adc_sclk)) |-> $stable(cfg_sdata));

  // R3: chip select high for at least two clocks between frames
  a_r3_min_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(adc_cs_n) && $past(gate)) |=> adc_cs_n);

  // R6: done only with chip select released
  a_r6_done_cs_high: assert property (@(posedge clk) disable iff (rst)
    cfg_done |-> adc_cs_n);

  // R6: done holds while both controls stay high
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (cfg_done && gate) |=> cfg_done);
endmodule

bind adc_cfg_writer adc_cfg_writer_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .run_start   (run_start),
  .conv_enable (conv_enable),
  .adc_cs_n    (adc_cs_n),
  .adc_sclk    (adc_sclk),
  .cfg_sdata   (cfg_sdata),
  .cfg_done    (cfg_done)
);

// File: tb/adc_cfg_writer_tb.sv
`timescale 1ns/1ps
module adc_cfg_writer_tb_top;
  localparam int N     = 3;
  localparam int HALF  = 2;
  localparam int GAP   = 3;
  localparam int FLEN  = 32 * HALF;
  localparam int PER   = FLEN + GAP;
  localparam int DONE_AT = (N - 1) * PER + FLEN;

  localparam logic [N*14-1:0] TBL = {6'h3F, 8'h01, 6'h05, 8'h7E, 6'h2A, 8'hC3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_start = 1'b0;
  logic conv_enable = 1'b0;
  logic adc_cs_n, adc_sclk, cfg_sdata, cfg_done;

  always #10 clk = ~clk;

  adc_cfg_writer #(
    .N_ENTRIES (N),
    .SCLK_HALF (HALF),
    .CS_GAP    (GAP),
    .CFG_TABLE (TBL)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .run_start   (run_start),
    .conv_enable (conv_enable),
    .adc_cs_n    (adc_cs_n),
    .adc_sclk    (adc_sclk),
    .cfg_sdata   (cfg_sdata),
    .cfg_done    (cfg_done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit reported = 1'b0;

  function automatic int exp_word(int i);
    int addr [N] = '{'h2A, 'h05, 'h3F};
    int data [N] = '{'hC3, 'h7E, 'h01};
    return (0 << 15) | (0 << 14) | (addr[i] << 8) | data[i];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    end
  endtask

  // Behavioural reference model
  bit e_cs = 1, e_sclk = 1, e_sd = 0, e_done = 0;
  bit running = 0, done_m = 0, started = 0;
  int pos = 0;

  task automatic model_at(input int p);
    int r, f, b;
    if (p >= DONE_AT) begin
      e_cs = 1; e_sclk = 1; e_sd = 0; e_done = 1; done_m = 1;
    end else begin
      f = p / PER; r = p % PER; e_done = 0;
      if (r < FLEN) begin
        b = r / (2 * HALF);
        e_cs = 0;
        e_sclk = ((r % (2 * HALF)) >= HALF);
        e_sd = (exp_word(f) >> (15 - b)) & 1;
      end else begin
        e_cs = 1; e_sclk = 1; e_sd = 0;
      end
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst || !(run_start && conv_enable)) begin
      running = 0; done_m = 0;
      e_cs = 1; e_sclk = 1; e_sd = 0; e_done = 0;
    end else if (!done_m) begin
      if (!running) begin running = 1; pos = 0; end
      else pos++;
      model_at(pos);
    end
  end

  // Per-cycle comparison and word capture
  bit prev_sclk = 1, prev_cs = 1;
  int cap_word = 0, cap_bits = 0;
  int words[$];

  always @(negedge clk) begin
    if (started) begin
      check(adc_cs_n == e_cs,     "R3 chip select",  adc_cs_n,  e_cs);
      check(adc_sclk == e_sclk,   "R4 serial clock", adc_sclk,  e_sclk);
      check(cfg_sdata == e_sd,    "R2 serial data",  cfg_sdata, e_sd);
      check(cfg_done == e_done,   "R6 done flag",    cfg_done,  e_done);
      if (prev_cs && !adc_cs_n) begin cap_word = 0; cap_bits = 0; end
      if (!adc_cs_n && adc_sclk && !prev_sclk) begin
        cap_word = (cap_word << 1) | cfg_sdata; cap_bits++;
      end
      if (!prev_cs === 1'b1 && adc_cs_n && cap_bits == 16) words.push_back(cap_word);
      prev_sclk = adc_sclk; prev_cs = adc_cs_n;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      report();
      $finish;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cycles(5);
    check(adc_cs_n && adc_sclk && !cfg_sdata && !cfg_done, "R8 reset idle",
          {adc_cs_n, adc_sclk, cfg_sdata, cfg_done}, 4'b1100);
    rst = 0;

    // R1: one control alone does nothing
    run_start = 1; conv_enable = 0;
    wait_cycles(20);
    check(adc_cs_n == 1, "R1 run only", adc_cs_n, 1);
    run_start = 0; conv_enable = 1;
    wait_cycles(10);
    check(adc_cs_n == 1 && cfg_done == 0, "R1 enable only", {adc_cs_n, cfg_done}, 2'b10);

    // Full sequence, R5 order and R2 content
    words.delete();
    run_start = 1;
    wait_cycles(1);
    check(adc_cs_n == 0, "R1 start on both high", adc_cs_n, 0);
    wait_cycles(DONE_AT + 10);
    check(cfg_done == 1, "R6 done after last frame", cfg_done, 1);
    check(words.size() == N, "R5 frame count", words.size(), N);
    for (int i = 0; i < N; i++)
      if (i < words.size()) check(words[i] == exp_word(i), "R5 R2 frame word", words[i], exp_word(i));
    wait_cycles(10);
    check(cfg_done == 1, "R6 done held", cfg_done, 1);

    // R7: drop enable clears done
    conv_enable = 0;
    wait_cycles(1);
    check(cfg_done == 0 && adc_cs_n == 1, "R7 done cleared", {cfg_done, adc_cs_n}, 2'b01);
    wait_cycles(3);

    // R7: abort mid second frame, then restart from entry 0
    conv_enable = 1;
    wait_cycles(PER + 20);
    run_start = 0;
    wait_cycles(1);
    check(adc_cs_n == 1 && adc_sclk == 1, "R7 abort releases", {adc_cs_n, adc_sclk}, 2'b11);
    words.delete();
    run_start = 1;
    wait_cycles(DONE_AT + 5);
    check(words.size() == N && words[0] == exp_word(0), "R7 restart from entry 0",
          words.size() > 0 ? words[0] : -1, exp_word(0));
    check(cfg_done == 1, "R7 done after restart", cfg_done, 1);

    // R8: reset mid sequence
    run_start = 0; wait_cycles(2); run_start = 1;
    wait_cycles(40);
    rst = 1;
    wait_cycles(2);
    check(adc_cs_n == 1 && cfg_done == 0, "R8 reset mid frame", {adc_cs_n, cfg_done}, 2'b10);
    rst = 0;
    wait_cycles(DONE_AT + 5);
    check(cfg_done == 1, "R8 completes after reset", cfg_done, 1);

    report();
    $finish;
  end
endmodule